// File: doc/BRIEF.md
# Multislope Integrating ADC Sequencer

This block sequences a charge-balancing integrating converter. It opens an integration window whose length is a whole number of mains cycles, picked by a 3-bit period code. The window is cut into fixed balance slots. At the end of each slot the block reads the integrator comparator. It then switches the positive or negative reference current onto the integrator for the following slot and keeps a signed up/down tally of these decisions. When the window closes, the integrator is held and a one-clock strobe asks the residue converter to read what charge is left. After that the signed count is presented together with a one-clock done pulse.

Autozero can be enabled per conversion. A zero-input integration then runs before the signal integration, and the result is the signal tally minus the zero tally. Conversions can run back to back (free-running), or each one can wait for a rising edge on a trigger input such as a mains zero-cross pulse. All inputs are synchronous to the clock. Converting counts to volts and controlling the analog front end are done elsewhere.

Top module: `msadc_seq`

## Requirements
- R1: While reset is asserted and right after it is released (trigger mode selected, no trigger), every output is low and the result is zero.
- R2: The period code selects a window of C mains cycles: code 0 gives C=1, code 1 gives C=2, code 2 gives C=5, code 3 gives C=10, code 4 gives C=20. Each mains cycle is SLOTS_PER_CYC slots of SLOT_CLKS clocks. Counting from the clock edge on which a phase starts, the residue strobe rises exactly N*SLOT_CLKS clocks later, where N = C*SLOTS_PER_CYC.
- R3: Period codes 5, 6 and 7 give the same window as code 0.
- R4: During a phase's first slot neither reference select is high. At the end of each slot except the last, the comparator is sampled. A value of 1 raises ref_neg_o for the whole next slot, and 0 raises ref_pos_o. The two are never high together, and neither is high outside an integration window.
- R5: A phase's count is the number of comparator samples that were 1 minus the number that were 0, taken over its N-1 balance decisions.
- R6: After each window, resid_o is high for exactly one clock. During that clock both reference selects and both mux selects are low.
- R7: done_o pulses for one clock, on the clock after the final residue strobe, and result_o takes the new count at that moment. result_o then stays unchanged until the next done_o.
- R8: With autozero on, zero_sel_o is high during a first (zero) window. in_sel_o goes high on the clock after that window's residue strobe. The result is the signal count minus the zero count. With autozero off only the signal window runs, and the result is the signal count. The two mux selects are never high together.
- R9: With trig_mode_i high, a conversion starts only on a rising edge of ext_trig_i seen while idle. A trigger held high does not start another conversion, and trigger edges during a conversion have no effect.
- R10: With trig_mode_i low, a new conversion starts two clocks after each done_o pulse (done, idle, then integrate).
- R11: The period code and the autozero enable are captured when a conversion starts. Changing them during that conversion does not alter its window lengths, its phases or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nplc_i | input | 3 | Integration period code |
| az_en_i | input | 1 | Autozero enable |
| trig_mode_i | input | 1 | 1: wait for trigger edge, 0: free-run |
| ext_trig_i | input | 1 | External start trigger |
| cmp_i | input | 1 | Integrator comparator, 1 = integrator above zero |
| ref_pos_o | output | 1 | Steer positive reference onto integrator |
| ref_neg_o | output | 1 | Steer negative reference onto integrator |
| in_sel_o | output | 1 | Connect signal input to integrator |
| zero_sel_o | output | 1 | Connect zero input to integrator |
| resid_o | output | 1 | Residue-sample strobe |
| done_o | output | 1 | Conversion complete pulse |
| result_o | output | CNT_W | Signed charge count |

## Verification
The bench sweeps every period code, including the three illegal ones, with autozero on and off and with four comparator patterns: all high, all low, alternating and irregular. It checks the reference selects slot by slot and pins the residue strobe to its exact clock. An off-by-one in the slot counter would shift that strobe or add a decision to the count. A design that counted the final sample, or applied a reference in the first slot, would show a count off by one or a stray select. The bench changes the period code, the autozero enable and the trigger in the middle of a conversion, and holds the trigger high afterwards. A design that re-read its settings would end the window at the wrong clock, and one that triggered on level would restart when it should stay idle. Back-to-back free-running conversions check the two-clock restart gap.

// File: rtl/msadc_pkg.sv
package msadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INTEG,
    ST_RESID,
    ST_DONE
  } seq_state_e;

  // mains cycles per window; illegal codes fall back to one cycle
  function automatic int unsigned nplc_cycles(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 5;
      3'd3:    return 10;
      3'd4:    return 20;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/msadc_period_lut.sv
module msadc_period_lut #(
  parameter int unsigned SLOTS_PER_CYC = 4,
  parameter int unsigned SLOT_W        = 7
) (
  input  logic [2:0]        code_i,
  output logic [SLOT_W-1:0] n_slots_o
);
  always_comb n_slots_o = SLOT_W'(msadc_pkg::nplc_cycles(code_i) * SLOTS_PER_CYC);
endmodule

// File: rtl/msadc_slot_timer.sv
module msadc_slot_timer #(
  parameter int unsigned SLOT_CLKS = 4,
  parameter int unsigned SLOT_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic [SLOT_W-1:0] n_slots_i,
  output logic              slot_end_o,
  output logic              last_slot_o
);
  localparam int unsigned CLK_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [CLK_W-1:0] CLK_MAX = CLK_W'(SLOT_CLKS - 1);

  logic [CLK_W-1:0]  clk_q;
  logic [SLOT_W-1:0] slot_q;

  assign slot_end_o  = run_i && (clk_q == CLK_MAX);
  assign last_slot_o = (slot_q == n_slots_i - SLOT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q  <= '0;
      slot_q <= '0;
    end else if (clear_i) begin
      clk_q  <= '0;
      slot_q <= '0;
    end else if (run_i) begin
      if (clk_q == CLK_MAX) begin
        clk_q  <= '0;
        slot_q <= slot_q + SLOT_W'(1);
      end else begin
        clk_q  <= clk_q + CLK_W'(1);
      end
    end
  end
endmodule

// File: rtl/msadc_balance.sv
module msadc_balance #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             hold_i,
  input  logic             cmp_i,
  output logic             ref_pos_o,
  output logic             ref_neg_o,
  output logic [CNT_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_pos_o <= 1'b0;
      ref_neg_o <= 1'b0;
      acc_o     <= '0;
    end else if (clear_i) begin
      ref_pos_o <= 1'b0;
      ref_neg_o <= 1'b0;
      acc_o     <= '0;
    end else if (hold_i) begin
      ref_pos_o <= 1'b0;
      ref_neg_o <= 1'b0;
    end else if (step_i) begin
      // integrator high -> pull it down and count one unit up
      ref_neg_o <= cmp_i;
      ref_pos_o <= !cmp_i;
      acc_o     <= acc_o + (cmp_i ? CNT_W'(1) : {CNT_W{1'b1}});
    end
  end
endmodule

// File: rtl/msadc_seq.sv
module msadc_seq #(
  parameter int unsigned SLOT_CLKS     = 4,
  parameter int unsigned SLOTS_PER_CYC = 4,
  parameter int unsigned CNT_W         = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2:0]              nplc_i,
  input  logic                    az_en_i,
  input  logic                    trig_mode_i,
  input  logic                    ext_trig_i,
  input  logic                    cmp_i,
  output logic                    ref_pos_o,
  output logic                    ref_neg_o,
  output logic                    in_sel_o,
  output logic                    zero_sel_o,
  output logic                    resid_o,
  output logic                    done_o,
  output logic signed [CNT_W-1:0] result_o
);
  import msadc_pkg::*;

  localparam int unsigned MAX_SLOTS = 20 * SLOTS_PER_CYC;
  localparam int unsigned SLOT_W    = $clog2(MAX_SLOTS + 1);

  seq_state_e        st_q;
  logic              phase_zero_q;
  logic              trig_q;
  logic [SLOT_W-1:0] n_slots_q, n_slots_lut;
  logic [CNT_W-1:0]  zero_q, result_q, acc;
  logic              slot_end, last_slot, win_end, step, go, bal_clear;

  msadc_period_lut #(
    .SLOTS_PER_CYC(SLOTS_PER_CYC),
    .SLOT_W       (SLOT_W)
  ) i_lut (
    .code_i   (nplc_i),
    .n_slots_o(n_slots_lut)
  );

  msadc_slot_timer #(
    .SLOT_CLKS(SLOT_CLKS),
    .SLOT_W   (SLOT_W)
  ) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (st_q != ST_INTEG),
    .run_i      (st_q == ST_INTEG),
    .n_slots_i  (n_slots_q),
    .slot_end_o (slot_end),
    .last_slot_o(last_slot)
  );

  assign win_end   = slot_end && last_slot;
  assign step      = slot_end && !last_slot;
  assign go        = (st_q == ST_IDLE) && (trig_mode_i ? (ext_trig_i && !trig_q) : 1'b1);
  assign bal_clear = go || ((st_q == ST_RESID) && phase_zero_q);

  msadc_balance #(
    .CNT_W(CNT_W)
  ) i_bal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (bal_clear),
    .step_i   (step),
    .hold_i   (win_end),
    .cmp_i    (cmp_i),
    .ref_pos_o(ref_pos_o),
    .ref_neg_o(ref_neg_o),
    .acc_o    (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      phase_zero_q <= 1'b0;
      trig_q       <= 1'b0;
      n_slots_q    <= SLOT_W'(SLOTS_PER_CYC);
      zero_q       <= '0;
      result_q     <= '0;
    end else begin
      trig_q <= ext_trig_i;
      case (st_q)
        ST_IDLE: if (go) begin
          st_q         <= ST_INTEG;
          phase_zero_q <= az_en_i;
          n_slots_q    <= n_slots_lut;
          zero_q       <= '0;
        end
        ST_INTEG: if (win_end) st_q <= ST_RESID;
        ST_RESID: begin
          if (phase_zero_q) begin
            phase_zero_q <= 1'b0;
            zero_q       <= acc;
            st_q         <= ST_INTEG;
          end else begin
            result_q <= acc - zero_q;
            st_q     <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_sel_o   = (st_q == ST_INTEG) && !phase_zero_q;
  assign zero_sel_o = (st_q == ST_INTEG) && phase_zero_q;
  assign resid_o    = (st_q == ST_RESID);
  assign done_o     = (st_q == ST_DONE);
  assign result_o   = result_q;
endmodule

// File: rtl/msadc_seq_chk.sv
module msadc_seq_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_pos_o,
  input logic             ref_neg_o,
  input logic             in_sel_o,
  input logic             zero_sel_o,
  input logic             resid_o,
  input logic             done_o,
  input logic [CNT_W-1:0] result_o
);
  assert_ref_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_pos_o && ref_neg_o));

  assert_ref_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_sel_o || zero_sel_o) |-> !(ref_pos_o || ref_neg_o));

  assert_resid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resid_o |=> !resid_o);

  assert_resid_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resid_o |-> !(ref_pos_o || ref_neg_o || in_sel_o || zero_sel_o));

  assert_done_after_resid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(resid_o));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  assert_mux_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_sel_o && zero_sel_o));

  assert_zero_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(zero_sel_o) |-> resid_o);

  assert_zero_then_sig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resid_o && $past(zero_sel_o)) |=> in_sel_o);
endmodule

bind msadc_seq msadc_seq_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_pos_o (ref_pos_o),
  .ref_neg_o (ref_neg_o),
  .in_sel_o  (in_sel_o),
  .zero_sel_o(zero_sel_o),
  .resid_o   (resid_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/test_msadc_seq.sv
module test_msadc_seq;
  localparam int S     = 4;
  localparam int SPC   = 4;
  localparam int CNT_W = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] nplc_i = 3'd0;
  logic az_en_i = 1'b0;
  logic trig_mode_i = 1'b1;
  logic ext_trig_i = 1'b0;
  logic cmp_i = 1'b0;
  logic ref_pos_o, ref_neg_o, in_sel_o, zero_sel_o, resid_o, done_o;
  logic signed [CNT_W-1:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  msadc_seq #(.SLOT_CLKS(S), .SLOTS_PER_CYC(SPC), .CNT_W(CNT_W)) i_msadc_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .nplc_i(nplc_i), .az_en_i(az_en_i),
    .trig_mode_i(trig_mode_i), .ext_trig_i(ext_trig_i), .cmp_i(cmp_i),
    .ref_pos_o(ref_pos_o), .ref_neg_o(ref_neg_o), .in_sel_o(in_sel_o),
    .zero_sel_o(zero_sel_o), .resid_o(resid_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int cycles_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 5;
      3: return 10;
      4: return 20;
      default: return 1;
    endcase
  endfunction

  function automatic bit bitf(input int pat, input int k);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return k[0];
      default: return ((k * 7 + 3) % 5) < 2;
    endcase
  endfunction

  function automatic int outs();
    return {ref_pos_o, ref_neg_o, in_sel_o, zero_sel_o, resid_o, done_o};
  endfunction

  // Called on a negedge. freerun=0: pulse trigger (idle); freerun=1: called at done+0.5
  task automatic run_conv(input int code, input bit az, input int pat, input bit freerun,
                          output int exp_res);
    int n;
    int ezero;
    int esig;
    string wtag;
    n = cycles_of(code) * SPC;
    ezero = 0;
    esig = 0;
    wtag = (code > 4) ? "R3" : "R2";
    nplc_i = 3'(code);
    az_en_i = az;
    if (!freerun) begin
      ext_trig_i = 1'b1;
      @(negedge clk_i);
      ext_trig_i = 1'b0;
    end else begin
      @(negedge clk_i);
      chk(!done_o && !in_sel_o && !zero_sel_o, "R10 idle gap", outs(), 0);
      @(negedge clk_i);
    end
    for (int ph = (az ? 0 : 1); ph < 2; ph++) begin
      int p;
      int sum;
      p = (ph == 0) ? (pat + 2) % 4 : pat;
      sum = 0;
      chk(zero_sel_o == (ph == 0) && in_sel_o == (ph == 1), "R8 mux phase",
          {in_sel_o, zero_sel_o}, (ph == 0) ? 1 : 2);
      for (int k = 0; k < n; k++) begin
        bit eneg;
        bit epos;
        eneg = (k == 0) ? 1'b0 : bitf(p, k - 1);
        epos = (k == 0) ? 1'b0 : !bitf(p, k - 1);
        chk(ref_neg_o == eneg && ref_pos_o == epos, "R4 ref select",
            {ref_pos_o, ref_neg_o}, {epos, eneg});
        chk(!resid_o, wtag, resid_o, 0);
        cmp_i = bitf(p, k);
        if (ph == 1 && k == 1) begin
          ext_trig_i = 1'b1;           // R9: edge during conversion
          nplc_i = 3'(code) ^ 3'd3;    // R11: settings change mid-run
          az_en_i = !az;
        end
        if (ph == 1 && k == 2) ext_trig_i = 1'b0;
        if (k < n - 1) sum += bitf(p, k) ? 1 : -1;
        repeat (S) @(negedge clk_i);
      end
      chk(resid_o, wtag, resid_o, 1);
      chk(!ref_pos_o && !ref_neg_o && !in_sel_o && !zero_sel_o, "R6 hold", outs(), 8'h2);
      if (ph == 0) ezero = sum;
      else esig = sum;
      @(negedge clk_i);
      if (ph == 0) chk(!resid_o, "R6 single strobe", resid_o, 0);
    end
    exp_res = esig - ezero;
    chk(done_o, "R7 done", done_o, 1);
    chk(result_o == exp_res, az ? "R8 result" : "R5 result", result_o, exp_res);
  endtask

  initial begin
    int er;
    repeat (3) @(negedge clk_i);
    chk(outs() == 0 && result_o == 0, "R1 in reset", outs(), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(outs() == 0 && result_o == 0, "R1 after reset", outs(), 0);

    for (int code = 0; code < 8; code++)
      for (int az = 0; az < 2; az++)
        for (int pat = 0; pat < 4; pat++) begin
          run_conv(code, az[0], pat, 1'b0, er);
          @(negedge clk_i);
          chk(!done_o, "R7 done pulse", done_o, 0);
          chk(result_o == er, "R7 result held", result_o, er);
          chk(!in_sel_o && !zero_sel_o, "R9 no restart", outs(), 0);
          repeat (2) @(negedge clk_i);
        end

    // R9: trigger held high starts only one conversion
    nplc_i = 3'd0;
    az_en_i = 1'b0;
    cmp_i = 1'b1;
    ext_trig_i = 1'b1;
    while (!done_o) @(negedge clk_i);
    chk(result_o == SPC - 1, "R5 held-trigger count", result_o, SPC - 1);
    begin
      bit quiet;
      quiet = 1'b1;
      repeat (40) begin
        @(negedge clk_i);
        if (in_sel_o || zero_sel_o) quiet = 1'b0;
      end
      chk(quiet, "R9 level trigger ignored", !quiet, 0);
    end
    ext_trig_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // R10: free-run back to back
    run_conv(2, 1'b0, 3, 1'b0, er);
    trig_mode_i = 1'b0;
    run_conv(1, 1'b1, 3, 1'b1, er);
    run_conv(6, 1'b0, 2, 1'b1, er);
    run_conv(3, 1'b1, 1, 1'b1, er);
    trig_mode_i = 1'b1;
    repeat (30) @(negedge clk_i);
    chk(!in_sel_o && !zero_sel_o && result_o == er, "R9 idle after free-run", result_o, er);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule